// File: doc/BRIEF.md
# Watermark-Gated Coalescing Interrupt Controller

This block collects the interrupt causes of a network interface into an 8-bit status vector and drives one interrupt line toward the CPU. Event pulses set status bits, and the bits stay set until software clears them with a write-one-to-clear request. A per-bit mask and a global enable select which pending causes may reach the line.

Two causes have hysteresis. The receive high-watermark cause is accepted only after the receive FIFO has hit empty. The transmit low-watermark cause is accepted only after the transmit FIFO has become full. Two arming flags record those extremes, and each flag is consumed when its watermark cause is accepted. A watermark event that arrives while its flag is clear is dropped.

Causes split into two classes. The four FIFO-level causes drive the line at once. The packet and DMA-completion causes wait out a loadable coalescing delay, counted in clock cycles, before the line rises. Software loads that delay to trade interrupt rate against latency.

Top module: `nic_irq_coalescer`

## Requirements
- R1: After reset the line is low, both arming flags are clear and the coalescing delay holds the RST_DELAY parameter value.
- R2: Status bit positions are: 0 rx packet, 1 rx DMA done, 2 rx empty, 3 rx high watermark, 4 tx packet, 5 tx DMA done, 6 tx full, 7 tx low watermark. An enabled, unmasked cause from the urgent set 0xcc (bits 2, 3, 6, 7) raises irq_o right after the edge that captures it.
- R3: An enabled, unmasked cause from the set 0x33 (bits 0, 1, 4, 5), with no urgent cause pending, raises irq_o D+1 edges after it first becomes pending, where D is the loaded delay. The line stays low before that.
- R4: An rx high-watermark event (evt_i bit 3) sets status bit 3 only while the rx arming flag is set. Acceptance clears the flag. Otherwise the event is dropped.
- R5: A tx low-watermark event (evt_i bit 7) sets status bit 7 only while the tx arming flag is set. Acceptance clears the flag. Otherwise the event is dropped.
- R6: A pulse on rx_empty_hit_i sets the rx arming flag and posts status bit 2. A pulse on tx_full_hit_i sets the tx arming flag and posts status bit 6.
- R7: A masked cause never drives irq_o but stays in status. Unmasking it later makes it pending, and it then follows R2 or R3.
- R8: irq_o is low whenever irq_en_i is low, and status is kept while it is low.
- R9: A 1 in clr_i clears that status bit at the next edge. irq_o falls in the cycle after the last pending cause is cleared. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: An urgent cause that arrives while the coalescing countdown runs raises irq_o at once, without waiting for the countdown.
- R11: delay_ld_i loads delay_val_i as the new delay. A delay of 0 raises a coalesced cause one edge after it becomes pending.
- R12: When nothing is pending, the countdown is discarded. The next coalesced cause waits a full new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Cause event pulses, one per status bit |
| rx_empty_hit_i | input | 1 | Pulse: receive FIFO reached empty |
| tx_full_hit_i | input | 1 | Pulse: transmit FIFO free space fell below one maximum copy |
| mask_i | input | 8 | Per-cause enable mask |
| irq_en_i | input | 1 | Global interrupt enable |
| clr_i | input | 8 | Write-one-to-clear request per status bit |
| delay_ld_i | input | 1 | Load strobe for the coalescing delay |
| delay_val_i | input | CNT_W | Coalescing delay in cycles |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The bench sweeps every cause bit against several delay values, including zero and one, and checks the line cycle by cycle. A design with the urgent set wrong, or with the countdown off by one edge, would raise the line at the wrong cycle.

Watermark events are sent both with and without a prior FIFO extreme, and a second event is sent after the flag has been consumed. A design that ignores the arming flags, or never consumes them, would fire on every watermark crossing.

Further cases cover:
- an urgent cause arriving mid-countdown, which a design routing all causes through the timer would delay;
- a clear that empties status and a re-post afterwards, where a stale countdown would fire early;
- a set and a clear on the same bit in the same cycle;
- unmasking and enabling after the fact, where a design that drops masked causes would stay silent.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned NUM_CAUSES = 8;
  typedef logic [NUM_CAUSES-1:0] cause_vec_t;

  localparam int unsigned CAUSE_RX_PACKET = 0;
  localparam int unsigned CAUSE_RX_DMA    = 1;
  localparam int unsigned CAUSE_RX_EMPTY  = 2;
  localparam int unsigned CAUSE_RX_HIGH   = 3;
  localparam int unsigned CAUSE_TX_PACKET = 4;
  localparam int unsigned CAUSE_TX_DMA    = 5;
  localparam int unsigned CAUSE_TX_FULL   = 6;
  localparam int unsigned CAUSE_TX_LOW    = 7;

  // causes that bypass coalescing
  localparam cause_vec_t URGENT_MASK = 8'hcc;
  // causes accepted only while their arming flag is set
  localparam cause_vec_t GATED_MASK  = 8'h88;
endpackage

// File: rtl/nic_irq_hyst.sv
module nic_irq_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic consume_i,
  output logic armed_o
);
  logic armed_q, armed_n;

  // arming wins over a same-cycle consume
  always_comb begin
    armed_n = armed_q;
    if (consume_i) armed_n = 1'b0;
    if (arm_i)     armed_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_n;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter cause_vec_t GATE_MASK = GATED_MASK
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t evt_i,
  input  cause_vec_t allow_i,
  input  cause_vec_t clr_i,
  output cause_vec_t set_o,
  output cause_vec_t status_o
);
  cause_vec_t set_w, stat_q, stat_n;

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_bit
    if (GATE_MASK[i]) begin : g_gated
      assign set_w[i] = evt_i[i] & allow_i[i];
    end else begin : g_free
      assign set_w[i] = evt_i[i] & (allow_i[i] | 1'b1);
    end
  end

  // set has priority over clear
  always_comb begin
    stat_n = (stat_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  assign set_o    = set_w;
  assign status_o = stat_q;
endmodule

// File: rtl/nic_irq_timer.sv
module nic_irq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_any_i,
  input  logic             pend_slow_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             elapsed_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q, run_n;
  logic             done_q, done_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    run_n  = run_q;
    done_n = done_q;
    cnt_n  = cnt_q;
    if (!pend_any_i) begin
      run_n  = 1'b0;
      done_n = 1'b0;
      cnt_n  = '0;
    end else if (!done_q) begin
      if (!run_q) begin
        if (pend_slow_i) begin
          if (delay_i == '0) begin
            done_n = 1'b1;
          end else begin
            run_n = 1'b1;
            cnt_n = delay_i;
          end
        end
      end else if (cnt_q <= CNT_ONE) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign elapsed_o = done_q;
endmodule

// File: rtl/nic_irq_coalescer.sv
module nic_irq_coalescer
  import nic_irq_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RST_DELAY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       evt_i,
  input  logic             rx_empty_hit_i,
  input  logic             tx_full_hit_i,
  input  logic [7:0]       mask_i,
  input  logic             irq_en_i,
  input  logic [7:0]       clr_i,
  input  logic             delay_ld_i,
  input  logic [CNT_W-1:0] delay_val_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] DELAY_INIT = CNT_W'(RST_DELAY);

  cause_vec_t       evt_all, allow, accepted, cause_q, pend;
  logic             rx_armed, tx_armed;
  logic             pend_fast, pend_slow, pend_any, elapsed;
  logic [CNT_W-1:0] delay_q, delay_n;

  // merge FIFO-extreme pulses into their status bits
  always_comb begin
    evt_all                 = evt_i;
    evt_all[CAUSE_RX_EMPTY] = evt_i[CAUSE_RX_EMPTY] | rx_empty_hit_i;
    evt_all[CAUSE_TX_FULL]  = evt_i[CAUSE_TX_FULL]  | tx_full_hit_i;
  end

  always_comb begin
    allow                = '0;
    allow[CAUSE_RX_HIGH] = rx_armed;
    allow[CAUSE_TX_LOW]  = tx_armed;
  end

  nic_irq_hyst u_rx_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (rx_empty_hit_i),
    .consume_i (accepted[CAUSE_RX_HIGH]),
    .armed_o   (rx_armed)
  );

  nic_irq_hyst u_tx_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (tx_full_hit_i),
    .consume_i (accepted[CAUSE_TX_LOW]),
    .armed_o   (tx_armed)
  );

  nic_irq_status #(.GATE_MASK(GATED_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_all),
    .allow_i  (allow),
    .clr_i    (clr_i),
    .set_o    (accepted),
    .status_o (cause_q)
  );

  // coalescing delay register
  always_comb begin
    delay_n = delay_q;
    if (delay_ld_i) delay_n = delay_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delay_q <= DELAY_INIT;
    else        delay_q <= delay_n;
  end

  assign pend      = cause_q & mask_i & {NUM_CAUSES{irq_en_i}};
  assign pend_fast = |(pend & URGENT_MASK);
  assign pend_slow = |(pend & ~URGENT_MASK);
  assign pend_any  = |pend;

  nic_irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_any_i  (pend_any),
    .pend_slow_i (pend_slow),
    .delay_i     (delay_q),
    .elapsed_o   (elapsed)
  );

  assign irq_o = pend_fast | (elapsed & pend_any);
endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] evt_i,
  input logic       rx_empty_hit_i,
  input logic       tx_full_hit_i,
  input logic [7:0] mask_i,
  input logic       irq_en_i,
  input logic [7:0] clr_i,
  input logic [7:0] cause_q,
  input logic       rx_armed,
  input logic       tx_armed,
  input logic       irq_o
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i); // R8

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((cause_q & mask_i) != 8'h00)); // R7

  AST_URGENT_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty_hit_i && !clr_i[2]) |=> (irq_o || !(irq_en_i && mask_i[2]))); // R6

  AST_RXHIGH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_q[3] && !rx_armed) |=> !cause_q[3]); // R4

  AST_TXLOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_q[7] && !tx_armed) |=> !cause_q[7]); // R5

  AST_RX_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[3] && rx_armed && !rx_empty_hit_i) |=> !rx_armed); // R4

  AST_TX_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[7] && tx_armed && !tx_full_hit_i) |=> !tx_armed); // R5

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == 8'hff && evt_i == 8'h00 && !rx_empty_hit_i && !tx_full_hit_i) |=> !irq_o); // R9
endmodule

bind nic_irq_coalescer nic_irq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_i          (evt_i),
  .rx_empty_hit_i (rx_empty_hit_i),
  .tx_full_hit_i  (tx_full_hit_i),
  .mask_i         (mask_i),
  .irq_en_i       (irq_en_i),
  .clr_i          (clr_i),
  .cause_q        (cause_q),
  .rx_armed       (rx_armed),
  .tx_armed       (tx_armed),
  .irq_o          (irq_o)
);

// File: tb/test_nic_irq_coalescer.sv
`timescale 1ns/1ps
module test_nic_irq_coalescer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       evt, mask, clr;
  logic             rx_hit, tx_hit, en, dly_ld;
  logic [CNT_W-1:0] dly_val;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nic_irq_coalescer #(.CNT_W(CNT_W), .RST_DELAY(8)) i_nic_irq_coalescer (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt),
    .rx_empty_hit_i (rx_hit),
    .tx_full_hit_i  (tx_hit),
    .mask_i         (mask),
    .irq_en_i       (en),
    .clr_i          (clr),
    .delay_ld_i     (dly_ld),
    .delay_val_i    (dly_val),
    .irq_o          (irq)
  );

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    evt = '0; mask = '0; clr = '0; rx_hit = 0; tx_hit = 0;
    en = 1'b1; dly_ld = 0; dly_val = '0;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_delay(input int d);
    dly_val = CNT_W'(d); dly_ld = 1'b1;
    tick();
    dly_ld = 1'b0;
  endtask

  task automatic post(input logic [7:0] b);
    evt = b;
    tick();
    evt = '0;
  endtask

  task automatic rx_extreme();
    rx_hit = 1'b1; tick(); rx_hit = 1'b0;
  endtask

  task automatic tx_extreme();
    tx_hit = 1'b1; tick(); tx_hit = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    chk(1'b0, "R1 reset line low");

    // R1: flags clear after reset, so a watermark event is dropped
    mask = 8'h88;
    post(8'h88);
    chk(1'b0, "R1 flags clear after reset");

    // R1: default delay 8 -> high on 9th edge after capture
    do_reset();
    mask = 8'h01;
    post(8'h01);
    for (int k = 1; k <= 9; k++) begin
      tick();
      chk(k == 9, "R1 reset delay value");
    end

    // R2 R3 R11: every cause against several delays
    for (int b = 0; b < 8; b++) begin
      for (int di = 0; di < 3; di++) begin
        int d;
        logic urgent;
        d = (di == 0) ? 0 : ((di == 1) ? 1 : 3);
        urgent = logic'((8'hcc >> b) & 8'h01);
        do_reset();
        set_delay(d);
        mask = 8'(1 << b);
        if (b == 3) rx_extreme();
        if (b == 7) tx_extreme();
        post(8'(1 << b));
        if (urgent) begin
          chk(1'b1, "R2 urgent cause immediate");
          tick();
          chk(1'b1, "R2 urgent cause held");
        end else begin
          chk(1'b0, "R3 coalesced cause waits");
          for (int k = 1; k <= d + 1; k++) begin
            tick();
            chk(k == d + 1, (d == 0) ? "R11 zero delay" : "R3 coalesced timing");
          end
        end
      end
    end

    // R4: rx high gating and consumption
    do_reset();
    mask = 8'h08;
    post(8'h08);
    chk(1'b0, "R4 rx high without flag dropped");
    rx_extreme();
    chk(1'b0, "R4 arming alone posts nothing unmasked");
    post(8'h08);
    chk(1'b1, "R4 rx high accepted when armed");
    clr = 8'h08; tick(); clr = '0;
    chk(1'b0, "R4 cleared");
    post(8'h08);
    chk(1'b0, "R4 flag consumed");

    // R5: tx low gating and consumption
    do_reset();
    mask = 8'h80;
    post(8'h80);
    chk(1'b0, "R5 tx low without flag dropped");
    tx_extreme();
    post(8'h80);
    chk(1'b1, "R5 tx low accepted when armed");
    clr = 8'h80; tick(); clr = '0;
    chk(1'b0, "R5 cleared");
    post(8'h80);
    chk(1'b0, "R5 flag consumed");

    // R6: extremes post their own bits
    do_reset();
    mask = 8'h04;
    rx_extreme();
    chk(1'b1, "R6 rx empty posts bit 2");
    do_reset();
    mask = 8'h40;
    tx_extreme();
    chk(1'b1, "R6 tx full posts bit 6");

    // R7: masked cause kept, unmask later
    do_reset();
    set_delay(2);
    mask = 8'h00;
    post(8'h01);
    tick(); tick(); tick();
    chk(1'b0, "R7 masked cause silent");
    mask = 8'h01;
    tick(); chk(1'b0, "R7 unmask wait 1");
    tick(); chk(1'b0, "R7 unmask wait 2");
    tick(); chk(1'b1, "R7 unmasked cause fires");

    // R8: global enable
    do_reset();
    mask = 8'h04; en = 1'b0;
    rx_extreme();
    tick();
    chk(1'b0, "R8 disabled line low");
    en = 1'b1;
    #1;
    chk(1'b1, "R8 enable exposes held status");

    // R9: clear drops line; set wins over clear
    do_reset();
    mask = 8'h04;
    rx_extreme();
    chk(1'b1, "R9 setup");
    clr = 8'h04; rx_hit = 1'b1; tick(); clr = '0; rx_hit = 1'b0;
    chk(1'b1, "R9 set wins over clear");
    clr = 8'h04; tick(); clr = '0;
    chk(1'b0, "R9 clear drops line");

    // R10: urgent cause during countdown
    do_reset();
    set_delay(10);
    mask = 8'h05;
    post(8'h01);
    tick(); tick(); tick();
    chk(1'b0, "R10 countdown running");
    rx_extreme();
    chk(1'b1, "R10 urgent cuts through countdown");

    // R12: countdown restarts after status empties
    do_reset();
    set_delay(3);
    mask = 8'h01;
    post(8'h01);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(k == 4, "R12 first delay");
    end
    clr = 8'h01; tick(); clr = '0;
    chk(1'b0, "R12 cleared");
    post(8'h01);
    chk(1'b0, "R12 repost waits");
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(k == 4, "R12 full new delay");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule